// File: doc/BRIEF.md
# FEAC Code Message Transmitter

This block sends a six-bit far-end alarm and control code toward the remote end of a DS3 link. The code is carried one bit per DS3 frame. The surrounding framer gives a single-cycle strobe for the FEAC overhead slot of each outbound frame, and the block answers with the level of `feac_bit` for that slot. A host uses a small four-register interface: it writes the code, sets the enable bit and the start bit in one control write, and then waits for the busy flag to drop or for the interrupt.

On an accepted start, the block takes a snapshot of the code and puts it inside a sixteen-bit message. It sends this message ten times in a row, which uses 160 frame slots, and then clears busy. Completion sets a sticky status bit, and that bit drives the interrupt output when the interrupt is enabled. When no message is in progress, the slot carries a steady one, which the far end reads as idle.

Top module: `feac_tx`

## Requirements
- R1: After reset, `feac_bit` is 1, `irq` is 0, and the busy bit (control register at address 1, bit 0) and the status bit (address 3, bit 0) both read 0.
- R2: A write to address 1 with data bits 2 and 1 both set starts a transmission when busy is 0. From the next cycle the busy bit reads 1. Bit 1 always reads back as 0, and bit 2 reads back as the stored enable.
- R3: The message slot index k runs from 0 to 15 in send order. Slot 0 is 0. Slots 1 to 6 are code bits 0 to 5 (the code is written at address 0, bits 5:0). Slot 7 is 0. Slots 8 to 15 are 1.
- R4: While busy, `feac_bit` shows the bit of the current slot. It moves to the next slot only after a cycle with `slot_stb` high, and it holds across cycles without a strobe.
- R5: The message is sent ten times. Busy still reads 1 before the 160th strobe and reads 0 after it.
- R6: Whenever busy is 0, `feac_bit` is 1 on every strobe until the next accepted start.
- R7: A start written while busy has no effect. A code written during a transmission does not change the message being sent.
- R8: A start written with data bit 2 clear does not begin a transmission.
- R9: Clearing the enable bit during a transmission aborts it. Busy returns to 0, the output returns to idle ones, and the status bit is not set.
- R10: Completing the tenth copy sets the status bit. The bit stays set until a read of address 3. That read returns 1, and the bit clears after it.
- R11: `irq` is high exactly when the status bit is set and the interrupt enable (address 2, bit 0) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status at address 3) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when rd_en is low |
| slot_stb | input | 1 | One-cycle pulse marking the FEAC slot of an outbound frame |
| feac_bit | output | 1 | Level to place in the current FEAC slot |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong slot index or a wrong snapshot of the code shows up on `feac_bit` at the very next strobe, so the bench compares every one of the 160 slots, with random gaps between strobes. A wrong repeat count appears only at the end of the run, as a busy flag that drops early or late around the 160th strobe, so busy is read just before and just after that strobe. Wrong abort or interrupt state appears at the register reads and on `irq` within a cycle or two of the triggering write.

// File: rtl/feac_tx_pkg.sv
package feac_tx_pkg;
  localparam int CODE_W  = 6;
  localparam int MSG_LEN = 16;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CODE  = 2'd0,
    REG_CTRL  = 2'd1,
    REG_IEN   = 2'd2,
    REG_ISTAT = 2'd3
  } reg_addr_e;

  localparam int CTRL_BUSY  = 0;
  localparam int CTRL_START = 1;
  localparam int CTRL_EN    = 2;

  // Whole message, index 0 is sent first.
  function automatic logic [MSG_LEN-1:0] build_msg(input logic [CODE_W-1:0] code);
    return {8'hFF, 1'b0, code, 1'b0};
  endfunction
endpackage

// File: rtl/feac_tx_regs.sv
module feac_tx_regs
  import feac_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              istat,
  output logic [DATA_W-1:0] rdata,
  output logic [CODE_W-1:0] code_q,
  output logic              en_q,
  output logic              ien_q,
  output logic              start_req,
  output logic              istat_clr
);
  logic wr_code, wr_ctrl, wr_ien;

  assign wr_code   = wr_en && (addr == REG_CODE);
  assign wr_ctrl   = wr_en && (addr == REG_CTRL);
  assign wr_ien    = wr_en && (addr == REG_IEN);
  assign start_req = wr_ctrl && wdata[CTRL_START] && wdata[CTRL_EN];
  assign istat_clr = rd_en && (addr == REG_ISTAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      en_q   <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_code) code_q <= wdata[CODE_W-1:0];
      if (wr_ctrl) en_q   <= wdata[CTRL_EN];
      if (wr_ien)  ien_q  <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        REG_CODE:  rdata[CODE_W-1:0] = code_q;
        REG_CTRL: begin
          rdata[CTRL_EN]   = en_q;
          rdata[CTRL_BUSY] = busy;
        end
        REG_IEN:   rdata[0] = ien_q;
        REG_ISTAT: rdata[0] = istat;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/feac_tx_seq.sv
module feac_tx_seq
  import feac_tx_pkg::*;
#(
  parameter int REPEATS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              en,
  input  logic              slot_stb,
  input  logic [CODE_W-1:0] code_in,
  output logic              busy,
  output logic              feac_bit,
  output logic              start_accept,
  output logic              msg_done,
  output logic              run_abort
);
  localparam int IDX_W = $clog2(MSG_LEN);
  localparam int REP_W = (REPEATS > 1) ? $clog2(REPEATS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MSG_LEN - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEATS - 1);

  logic [CODE_W-1:0]  snap_q;
  logic [IDX_W-1:0]   idx_q;
  logic [REP_W-1:0]   rep_q;
  logic               busy_q;
  logic [MSG_LEN-1:0] msg_vec;
  logic               advance, last_slot;

  assign msg_vec = build_msg(snap_q);

  assign start_accept = start_req && !busy_q;
  assign run_abort    = busy_q && !en;
  assign advance      = busy_q && en && slot_stb;
  assign last_slot    = (idx_q == IDX_LAST) && (rep_q == REP_LAST);
  assign msg_done     = advance && last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      rep_q  <= '0;
      snap_q <= '0;
    end else if (run_abort || msg_done) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      rep_q  <= '0;
    end else if (start_accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      rep_q  <= '0;
      snap_q <= code_in;
    end else if (advance) begin
      if (idx_q == IDX_LAST) begin
        idx_q <= '0;
        rep_q <= rep_q + 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign feac_bit = busy_q ? msg_vec[idx_q] : 1'b1;
endmodule

// File: rtl/feac_tx_irq.sv
module feac_tx_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic ien,
  output logic istat,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       istat <= 1'b0;
    else if (set_evt) istat <= 1'b1;
    else if (clr_evt) istat <= 1'b0;
  end

  assign irq = istat && ien;
endmodule

// File: rtl/feac_tx.sv
module feac_tx
  import feac_tx_pkg::*;
#(
  parameter int REPEATS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              slot_stb,
  output logic              feac_bit,
  output logic              irq
);
  logic [CODE_W-1:0] code_q;
  logic en_q, ien_q, start_req, istat_clr, istat;
  logic busy, start_accept, msg_done, run_abort;

  feac_tx_regs u_regs (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata,
    .busy, .istat, .rdata, .code_q, .en_q, .ien_q,
    .start_req, .istat_clr
  );

  feac_tx_seq #(.REPEATS(REPEATS)) u_seq (
    .clk, .rst_n, .start_req, .en(en_q), .slot_stb,
    .code_in(code_q), .busy, .feac_bit, .start_accept,
    .msg_done, .run_abort
  );

  feac_tx_irq u_irq (
    .clk, .rst_n, .set_evt(msg_done), .clr_evt(istat_clr),
    .ien(ien_q), .istat, .irq
  );
endmodule

// File: rtl/feac_tx_chk.sv
module feac_tx_chk
  import feac_tx_pkg::*;
#(
  parameter int REPEATS = 10
) (
  input logic clk,
  input logic rst_n,
  input logic slot_stb,
  input logic feac_bit,
  input logic irq,
  input logic busy,
  input logic start_accept,
  input logic msg_done,
  input logic run_abort,
  input logic istat,
  input logic ien_q
);
  localparam int TOTAL = REPEATS * MSG_LEN;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] stb_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     stb_cnt <= '0;
    else if (start_accept)          stb_cnt <= '0;
    else if (busy && slot_stb)      stb_cnt <= stb_cnt + 1'b1;
  end

  AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> feac_bit) else $error("idle not ones"); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> busy) else $error("start not taken"); // R2
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(slot_stb) && !$past(start_accept)) |-> $stable(feac_bit))
    else $error("bit moved without strobe"); // R4
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> (stb_cnt == CNT_W'(TOTAL - 1))) else $error("wrong length"); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> (!busy && istat)) else $error("done state"); // R10
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (run_abort && !istat) |=> (!busy && !istat)) else $error("abort state"); // R9
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ien_q && istat)) else $error("irq source"); // R11
endmodule

bind feac_tx feac_tx_chk #(.REPEATS(REPEATS)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .feac_bit(feac_bit),
  .irq(irq), .busy(busy), .start_accept(start_accept), .msg_done(msg_done),
  .run_abort(run_abort), .istat(istat), .ien_q(ien_q)
);

// File: tb/feac_tx_tb_top.sv
`timescale 1ns/1ps
module feac_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, slot_stb = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic feac_bit, irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  feac_tx dut_i (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .slot_stb, .feac_bit, .irq
  );

  function automatic logic exp_bit(input logic [5:0] code, input int k);
    if (k == 0 || k == 7) return 1'b0;
    if (k >= 8) return 1'b1;
    return code[k-1];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic gap();
    repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  task automatic strobe(output logic b);
    @(negedge clk); b = feac_bit; slot_stb = 1'b1;
    @(negedge clk); slot_stb = 1'b0;
  endtask

  // Runs a full transmission already started with code; optional mid-run disturbance.
  task automatic run_msg(input logic [5:0] code, input logic ien, input bit disturb);
    logic b; logic [7:0] d;
    for (int s = 0; s < 160; s++) begin
      gap();
      if (disturb && s == 40) begin
        wr(2'd0, {2'b0, ~code});
        wr(2'd1, 8'h06);
      end
      if (s == 159) begin
        rd(2'd1, d);
        check("R5 busy before last strobe", d & 8'h01, 8'h01);
      end
      strobe(b);
      check(disturb ? "R7 bit" : "R3 R4 bit", {7'b0, b}, {7'b0, exp_bit(code, s % 16)});
    end
    rd(2'd1, d);
    check("R5 busy after last strobe", d & 8'h01, 8'h00);
    check("R6 idle after completion", {7'b0, feac_bit}, 8'h01);
    check("R11 irq", {7'b0, irq}, {7'b0, ien});
    rd(2'd3, d);
    check("R10 status set", d, 8'h01);
    rd(2'd3, d);
    check("R10 status cleared by read", d, 8'h00);
    check("R11 irq after clear", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic b; logic [5:0] code;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 feac_bit", {7'b0, feac_bit}, 8'h01);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd(2'd1, d); check("R1 ctrl", d, 8'h00);
    rd(2'd3, d); check("R1 status", d, 8'h00);

    // R8: start without enable
    wr(2'd0, 8'h2A);
    wr(2'd1, 8'h02);
    rd(2'd1, d); check("R8 no start without enable", d, 8'h00);
    strobe(b); check("R8 idle ones", {7'b0, b}, 8'h01);
    strobe(b); check("R6 idle ones", {7'b0, b}, 8'h01);

    // R2 + directed full run with interrupt enabled
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h06);
    rd(2'd1, d); check("R2 busy set, start reads 0", d, 8'h05);
    run_msg(6'h2A, 1'b1, 1'b0);
    strobe(b); check("R6 idle after run", {7'b0, b}, 8'h01);

    // R7: start and code write while busy
    wr(2'd0, 8'h15);
    wr(2'd1, 8'h06);
    run_msg(6'h15, 1'b1, 1'b1);

    // R9: abort by clearing enable
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h06);
    for (int s = 0; s < 20; s++) begin
      strobe(b);
      check("R3 bit before abort", {7'b0, b}, {7'b0, exp_bit(6'h00, s % 16)});
    end
    wr(2'd1, 8'h00);
    @(negedge clk);
    rd(2'd1, d); check("R9 busy cleared", d, 8'h00);
    for (int s = 0; s < 3; s++) begin
      strobe(b); check("R9 idle after abort", {7'b0, b}, 8'h01);
    end
    rd(2'd3, d); check("R9 no status", d, 8'h00);
    check("R9 no irq", {7'b0, irq}, 8'h00);

    // R11: interrupt disabled, random codes
    wr(2'd2, 8'h00);
    for (int n = 0; n < 3; n++) begin
      code = 6'($urandom_range(0, 63));
      wr(2'd0, {2'b0, code});
      wr(2'd1, 8'h06);
      run_msg(code, 1'b0, 1'b0);
    end
    // corner codes with interrupt enabled
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h3F); wr(2'd1, 8'h06); run_msg(6'h3F, 1'b1, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule